// File: doc/BRIEF.md
# Counter-Enable Mask Unit with Selectable Privileged Layout

This block keeps the two counter-enable masks of a hart: one lists the counters that supervisor code may read, the other lists those that user code may read. Software reaches the masks through CSR addresses. Two generations of the privileged architecture name them differently. A static layout input picks which pair of addresses is live. The same two physical registers sit behind both pairs, so a value written under one layout can be read under the other.

The CSR port takes a valid strobe, a write enable, an address and write data. It returns read data, a hit flag and an illegal-access flag. An address that belongs to the inactive layout raises the illegal flag and leaves the masks untouched. A second, read-only port checks a user-level counter access. It takes a counter address in the 0xC00–0xC1F window and flags it as illegal when the effective mask for the current privilege has the matching bit clear. The counters, trap entry and all other CSRs are outside this block.

Top module: `ctr_gate_csr`

## Requirements
- R1: A synchronous active-high reset clears both masks to zero.
- R2: When `new_layout` is 1, address 0x306 reads and writes the supervisor mask and address 0x106 reads and writes the user mask. Such an access asserts `csr_hit` and leaves `csr_illegal` low.
- R3: When `new_layout` is 0, address 0x321 reads and writes the supervisor mask and address 0x320 reads and writes the user mask. Such an access asserts `csr_hit` and leaves `csr_illegal` low.
- R4: When `new_layout` is 0, a read or write to 0x306 or 0x106 asserts `csr_illegal`, deasserts `csr_hit`, returns zero read data and changes neither mask.
- R5: When `new_layout` is 1, a read or write to 0x320 or 0x321 asserts `csr_illegal`, deasserts `csr_hit`, returns zero read data and changes neither mask.
- R6: For any other address, `csr_hit` and `csr_illegal` stay low, read data is zero and neither mask changes, even with `csr_we` high.
- R7: Privilege is encoded as 00 for user, 01 for supervisor, and 11 (or 10) for machine. `eff_mask` equals the user mask in user mode, the supervisor mask in supervisor mode, and all ones otherwise.
- R8: With `ctr_valid` high and `ctr_addr` in 0xC00..0xC1F, `ctr_illegal` is the inverse of bit (`ctr_addr` − 0xC00) of `eff_mask`. An address outside that window never raises `ctr_illegal`.
- R9: A legal write takes effect at the next rising clock edge. Read data and all flags are combinational from the current inputs and mask state.
- R10: Both layouts share the same storage. A value written through one layout's address reads back through the matching address of the other layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| new_layout | input | 1 | Static layout select: 1 = newer names (0x306/0x106), 0 = older names (0x321/0x320) |
| cur_priv | input | 2 | Current privilege: 00 user, 01 supervisor, 1x machine |
| csr_valid | input | 1 | CSR access strobe |
| csr_we | input | 1 | Write enable for the CSR access |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data, zero when there is no hit |
| csr_hit | output | 1 | Access targets a live mask address |
| csr_illegal | output | 1 | Access targets a mask address of the inactive layout |
| ctr_valid | input | 1 | Counter-read check strobe |
| ctr_addr | input | 12 | Counter CSR address to check |
| ctr_illegal | output | 1 | Counter read is disabled at the current privilege |
| eff_mask | output | 32 | Effective counter-enable mask for the current privilege |

## Verification
The hardest case to reach is a write with enable high to an address of the inactive layout, which must leave storage untouched. Its effect only shows on a later read, and that read must go through the other layout's names, so the stimulus has to switch `new_layout` partway through the run. The vector table writes distinct patterns through one layout, tries to overwrite them through the dead names, and then flips the layout. It then reads the patterns back through the other pair. This also exercises the shared storage. A sweep over all three privilege levels and all 32 counter indices then compares the counter check against a reference copy of the masks.

// File: rtl/ctr_gate_pkg.sv
package ctr_gate_pkg;
  typedef enum logic [1:0] {
    PRIV_U   = 2'b00,
    PRIV_S   = 2'b01,
    PRIV_RSV = 2'b10,
    PRIV_M   = 2'b11
  } priv_e;

  typedef struct packed {
    logic sel_s;
    logic sel_u;
    logic hit;
    logic illegal;
  } csr_dec_t;
endpackage

// File: rtl/ctr_gate_decode.sv
module ctr_gate_decode #(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] NEW_S_ADDR = 12'h306,
  parameter logic [ADDR_W-1:0] NEW_U_ADDR = 12'h106,
  parameter logic [ADDR_W-1:0] OLD_S_ADDR = 12'h321,
  parameter logic [ADDR_W-1:0] OLD_U_ADDR = 12'h320
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     new_layout,
  input  logic                     valid,
  input  logic [ADDR_W-1:0]        addr,
  output ctr_gate_pkg::csr_dec_t   dec
);
  logic is_new_s, is_new_u, is_old_s, is_old_u;

  always_comb begin
    is_new_s = (addr == NEW_S_ADDR);
    is_new_u = (addr == NEW_U_ADDR);
    is_old_s = (addr == OLD_S_ADDR);
    is_old_u = (addr == OLD_U_ADDR);
    if (new_layout) begin
      dec.sel_s   = valid && is_new_s;
      dec.sel_u   = valid && is_new_u;
      dec.illegal = valid && (is_old_s || is_old_u);
    end else begin
      dec.sel_s   = valid && is_old_s;
      dec.sel_u   = valid && is_old_u;
      dec.illegal = valid && (is_new_s || is_new_u);
    end
    dec.hit = dec.sel_s || dec.sel_u;
  end

  // R4 R5
  hit_xor_illegal_chk: assert property (@(posedge clk) disable iff (rst)
    !(dec.hit && dec.illegal));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |-> (!dec.hit && !dec.illegal));
endmodule

// File: rtl/ctr_gate_regs.sv
module ctr_gate_regs #(
  parameter int unsigned MASK_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              sel_s,
  input  logic              sel_u,
  input  logic [MASK_W-1:0] wdata,
  output logic [MASK_W-1:0] s_mask,
  output logic [MASK_W-1:0] u_mask
);
  localparam int unsigned N_MASK = 2;

  logic [N_MASK-1:0] sel;
  logic [MASK_W-1:0] q [N_MASK];

  assign sel    = {sel_u, sel_s};
  assign s_mask = q[0];
  assign u_mask = q[1];

  for (genvar g = 0; g < N_MASK; g++) begin : g_mask
    always_ff @(posedge clk) begin
      if (rst)
        q[g] <= '0;
      else if (we && sel[g])
        q[g] <= wdata;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (s_mask == '0 && u_mask == '0));

  // R9
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (we && sel_s) |=> (s_mask == $past(wdata)));

  // R4 R5 R6
  no_stray_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel_s && !sel_u) |=> ($stable(s_mask) && $stable(u_mask)));
endmodule

// File: rtl/ctr_gate_check.sv
module ctr_gate_check #(
  parameter int unsigned MASK_W = 32,
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CTR_BASE = 12'hC00
) (
  input  logic                clk,
  input  logic                rst,
  input  ctr_gate_pkg::priv_e priv,
  input  logic [MASK_W-1:0]   s_mask,
  input  logic [MASK_W-1:0]   u_mask,
  input  logic                ctr_valid,
  input  logic [ADDR_W-1:0]   ctr_addr,
  output logic [MASK_W-1:0]   eff_mask,
  output logic                ctr_illegal
);
  import ctr_gate_pkg::*;
  localparam int unsigned IDX_W = $clog2(MASK_W);

  logic [ADDR_W-1:0] offset;
  logic              in_window;
  logic [IDX_W-1:0]  idx;

  always_comb begin
    unique case (priv)
      PRIV_U:  eff_mask = u_mask;
      PRIV_S:  eff_mask = s_mask;
      default: eff_mask = '1;
    endcase
    offset      = ctr_addr - CTR_BASE;
    in_window   = (offset < ADDR_W'(MASK_W));
    idx         = offset[IDX_W-1:0];
    ctr_illegal = ctr_valid && in_window && !eff_mask[idx];
  end

  // R7
  machine_never_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (priv == PRIV_M) |-> !ctr_illegal);

  // R8
  window_only_chk: assert property (@(posedge clk) disable iff (rst)
    ctr_illegal |-> (ctr_valid && ctr_addr >= CTR_BASE));
endmodule

// File: rtl/ctr_gate_csr.sv
module ctr_gate_csr #(
  parameter int unsigned MASK_W = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              new_layout,
  input  logic [1:0]        cur_priv,
  input  logic              csr_valid,
  input  logic              csr_we,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [MASK_W-1:0] csr_wdata,
  output logic [MASK_W-1:0] csr_rdata,
  output logic              csr_hit,
  output logic              csr_illegal,
  input  logic              ctr_valid,
  input  logic [ADDR_W-1:0] ctr_addr,
  output logic              ctr_illegal,
  output logic [MASK_W-1:0] eff_mask
);
  import ctr_gate_pkg::*;

  csr_dec_t          dec;
  logic [MASK_W-1:0] s_mask, u_mask;

  ctr_gate_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst(rst), .new_layout(new_layout),
    .valid(csr_valid), .addr(csr_addr), .dec(dec)
  );

  ctr_gate_regs #(.MASK_W(MASK_W)) u_regs (
    .clk(clk), .rst(rst), .we(csr_we), .sel_s(dec.sel_s), .sel_u(dec.sel_u),
    .wdata(csr_wdata), .s_mask(s_mask), .u_mask(u_mask)
  );

  ctr_gate_check #(.MASK_W(MASK_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .priv(priv_e'(cur_priv)),
    .s_mask(s_mask), .u_mask(u_mask), .ctr_valid(ctr_valid),
    .ctr_addr(ctr_addr), .eff_mask(eff_mask), .ctr_illegal(ctr_illegal)
  );

  always_comb begin
    csr_hit     = dec.hit;
    csr_illegal = dec.illegal;
    if (dec.sel_s)      csr_rdata = s_mask;
    else if (dec.sel_u) csr_rdata = u_mask;
    else                csr_rdata = '0;
  end

  // R2 R3
  hit_has_data_chk: assert property (@(posedge clk) disable iff (rst)
    !csr_hit |-> (csr_rdata == '0));
endmodule

// File: tb/ctr_gate_csr_test.sv
module ctr_gate_csr_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        new_layout = 1;
  logic [1:0]  cur_priv = 2'b11;
  logic        csr_valid = 0, csr_we = 0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        csr_hit, csr_illegal;
  logic        ctr_valid = 0;
  logic [11:0] ctr_addr = '0;
  logic        ctr_illegal;
  logic [31:0] eff_mask;

  int checks = 0, fails = 0;
  logic [31:0] m_s = '0, m_u = '0;

  always #10 clk = ~clk;

  ctr_gate_csr uut (.*);

  typedef struct packed {
    logic        lay;
    logic        we;
    logic [11:0] addr;
    logic [31:0] wd;
    logic        ill;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 12'h306, 32'hAAAA_0005, 1'b0},
    '{1'b1, 1'b1, 12'h106, 32'h0000_0003, 1'b0},
    '{1'b1, 1'b0, 12'h306, 32'h0,         1'b0},
    '{1'b1, 1'b0, 12'h106, 32'h0,         1'b0},
    '{1'b1, 1'b1, 12'h320, 32'hFFFF_FFFF, 1'b1},
    '{1'b1, 1'b1, 12'h321, 32'hFFFF_FFFF, 1'b1},
    '{1'b1, 1'b0, 12'h321, 32'h0,         1'b1},
    '{1'b1, 1'b0, 12'h306, 32'h0,         1'b0},
    '{1'b1, 1'b1, 12'h123, 32'h1234_5678, 1'b0},
    '{1'b1, 1'b0, 12'h300, 32'h0,         1'b0},
    '{1'b0, 1'b0, 12'h321, 32'h0,         1'b0},
    '{1'b0, 1'b0, 12'h320, 32'h0,         1'b0},
    '{1'b0, 1'b1, 12'h321, 32'h0000_00F0, 1'b0},
    '{1'b0, 1'b1, 12'h320, 32'h0000_000C, 1'b0},
    '{1'b0, 1'b1, 12'h306, 32'hFFFF_FFFF, 1'b1},
    '{1'b0, 1'b1, 12'h106, 32'hFFFF_FFFF, 1'b1},
    '{1'b0, 1'b0, 12'h106, 32'h0,         1'b1},
    '{1'b1, 1'b0, 12'h306, 32'h0,         1'b0},
    '{1'b1, 1'b0, 12'h106, 32'h0,         1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model: R2/R3 live names, R4/R5 dead names, R6 others
  task automatic access(input logic lay, input logic we, input logic [11:0] a,
                        input logic [31:0] wd, input logic tab_ill);
    logic s_hit, u_hit, ill;
    logic [31:0] exp_rd;
    s_hit = lay ? (a == 12'h306) : (a == 12'h321);
    u_hit = lay ? (a == 12'h106) : (a == 12'h320);
    ill   = lay ? (a == 12'h320 || a == 12'h321) : (a == 12'h306 || a == 12'h106);
    exp_rd = s_hit ? m_s : (u_hit ? m_u : 32'h0);
    new_layout = lay; csr_valid = 1; csr_we = we; csr_addr = a; csr_wdata = wd;
    #5;
    // R9: read data before the edge shows the old value
    chk(lay ? "R2/R9 rdata" : "R3/R9 rdata", csr_rdata, exp_rd);
    chk("R2 R3 hit", {31'b0, csr_hit}, {31'b0, s_hit | u_hit});
    chk(lay ? "R5 R6 illegal" : "R4 R6 illegal", {31'b0, csr_illegal}, {31'b0, ill});
    chk("R4 R5 table", {31'b0, ill}, {31'b0, tab_ill});
    @(posedge clk);
    if (we && s_hit) m_s = wd;
    if (we && u_hit) m_u = wd;
    @(negedge clk);
    csr_valid = 0; csr_we = 0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: both masks zero after reset
    access(1'b1, 1'b0, 12'h306, 32'h0, 1'b0);
    access(1'b1, 1'b0, 12'h106, 32'h0, 1'b0);
    for (int i = 0; i < NV; i++)
      access(VECS[i].lay, VECS[i].we, VECS[i].addr, VECS[i].wd, VECS[i].ill);
    // R10: storage written under old layout visible under new layout
    chk("R10 shared S", m_s, 32'h0000_00F0);
    chk("R10 shared U", m_u, 32'h0000_000C);

    // R7 R8: sweep privilege and counter index
    access(1'b1, 1'b1, 12'h306, 32'h8000_00A5, 1'b0);
    access(1'b1, 1'b1, 12'h106, 32'h0000_0C21, 1'b0);
    for (int p = 0; p < 4; p++) begin
      logic [31:0] em;
      cur_priv = p[1:0];
      em = (p == 0) ? m_u : (p == 1) ? m_s : 32'hFFFF_FFFF;
      #1;
      chk("R7 eff_mask", eff_mask, em);
      for (int k = 0; k < 32; k++) begin
        ctr_valid = 1; ctr_addr = 12'hC00 + 12'(k);
        #1;
        chk("R8 counter gate", {31'b0, ctr_illegal}, {31'b0, ~em[k]});
      end
      ctr_addr = 12'hC20; #1;
      chk("R8 above window", {31'b0, ctr_illegal}, 32'h0);
      ctr_addr = 12'hBFF; #1;
      chk("R8 below window", {31'b0, ctr_illegal}, 32'h0);
      ctr_valid = 0;
    end

    // R1: reset clears after writes
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    m_s = '0; m_u = '0;
    access(1'b0, 1'b0, 12'h321, 32'h0, 1'b0);
    access(1'b0, 1'b0, 12'h320, 32'h0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule